// File: doc/BRIEF.md
# Periodic Interrupt Timer with Priority

This block raises interrupt requests at a fixed period. A down counter is loaded with a programmed modulus. On each timer tick it counts down by one. When it reaches its final tick it reloads and flags an expiry. The tick is either every system clock or, when the prescale enable is set, every `PRESC_DIV` clocks.

An expiry makes a request pending at a programmed 3-bit priority. The pending request is presented on a level output and weighed against an external request level. When both sit at the same level, the timer wins. The interrupt controller then acknowledges a level. If that level matches the pending timer request, the block returns its programmed 8-bit vector in the same cycle and drops the request.

Software reaches two 16-bit registers through a plain write strobe and a combinational read port.
- The control register, at address 0, holds the level and the vector.
- The timing register, at address 1, holds the modulus and the prescale enable.

The acknowledge and vector are single-cycle control handshakes with no back-pressure. The vector is only meaningful while `vec_valid` is high.

Top module: `pit_timer`

## Requirements
- R1: Control register (address 0) reads with bits 15:11 as zero, the request level in bits 10:8 and the vector in bits 7:0; bits 10:0 are writable at any time.
- R2: After reset the control register reads 0x000F (level 0, vector 0x0F), the timing register reads 0x0000, and no request is presented.
- R3: Timing register (address 1) holds the modulus in bits 7:0 and the prescale enable in bit 8, reads bits 15:9 as zero, and a write to it restarts the count from the new modulus.
- R4: With the prescale enable clear and modulus N > 0, a request becomes visible N clocks after the timing write edge and then every N clocks, with the counter reloading itself so the period does not drift.
- R5: With the prescale enable set, each count step takes `PRESC_DIV` clocks, so the first request appears N×`PRESC_DIV` clocks after the write.
- R6: A modulus of 0 stops the counter and no request is ever raised.
- R7: A request level of 0 suppresses requests without stopping the counter; expiries while disabled are discarded, and a later non-zero level sees the next expiry on the original schedule.
- R8: A pending request at level L drives `irq_level` to L and `irq_pit` high when L is not below `ext_level`.
- R9: When the external level equals the pending timer level the timer source is chosen (`irq_pit` high); when the external level is higher, `irq_level` follows it and `irq_pit` is low.
- R10: An acknowledge at the pending timer level asserts `vec_valid` with the programmed vector in the same cycle and clears the request at that clock edge; an acknowledge at any other level returns no vector and leaves the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 timing |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| ext_level | input | 3 | Level of the competing external request |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Winning request level, 0 when none |
| irq_pit | output | 1 | High when the timer owns the presented level |
| vec_valid | output | 1 | Vector output is valid for this acknowledge |
| vec_data | output | 8 | Supplied interrupt vector |

## Verification
Three patterns exercise the count path.
- Plain modulus counting with a second period after an acknowledge. This separates a correct self-reload from one that restarts at the acknowledge.
- A prescaled count. This shows whether the divider is applied per step or only once.
- A disabled level that is enabled mid-period. This tells a counter that keeps running from one that halts, and a dropped expiry from a stored one.

On the priority path, the external level is set below, equal to and above the pending level. Acknowledges are tried at a wrong level and at the right one. These separate tie handling, source selection and vector gating.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam int MOD_W = 8;
  localparam int REG_W = 16;
  localparam logic [VEC_W-1:0] RST_VECTOR = 8'h0F;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    logic [VEC_W-1:0] vector;
  } ctl_t;

  typedef struct packed {
    logic             presc;
    logic [MOD_W-1:0] modulus;
  } tmr_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output ctl_t             ctl_q,
  output tmr_t             tmr_q,
  output logic             tmr_load,
  output tmr_t             tmr_load_val
);
  localparam int CTL_BITS = LVL_W + VEC_W;
  localparam int TMR_BITS = MOD_W + 1;

  assign tmr_load     = reg_wr && reg_addr;
  assign tmr_load_val = tmr_t'(reg_wdata[TMR_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '{level: '0, vector: RST_VECTOR};
      tmr_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr) tmr_q <= tmr_load_val;
      else          ctl_q <= ctl_t'(reg_wdata[CTL_BITS-1:0]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata[TMR_BITS-1:0] = tmr_q;
    else          reg_rdata[CTL_BITS-1:0] = ctl_q;
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int PRESC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  tmr_t tmr_q,
  input  logic tmr_load,
  input  tmr_t tmr_load_val,
  output logic expire
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [MOD_W-1:0] cnt_q;
  logic             tick;
  logic             running;

  assign running = (tmr_q.modulus != '0);
  assign tick    = !tmr_q.presc || (pre_q == PRE_LAST);
  assign expire  = running && tick && (cnt_q == MOD_W'(1)) && !tmr_load;

  always_ff @(posedge clk) begin
    if (!rst_n || tmr_load || !tmr_q.presc) pre_q <= '0;
    else if (pre_q == PRE_LAST)              pre_q <= '0;
    else                                     pre_q <= pre_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (tmr_load)          cnt_q <= tmr_load_val.modulus;
    else if (running && tick) begin
      if (cnt_q <= MOD_W'(1))   cnt_q <= tmr_q.modulus;
      else                      cnt_q <= cnt_q - MOD_W'(1);
    end
  end
endmodule

// File: rtl/pit_irq.sv
module pit_irq
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  ctl_t             ctl_q,
  input  logic [LVL_W-1:0] ext_level,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [LVL_W-1:0] irq_level,
  output logic             irq_pit,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data
);
  logic pend_q;
  logic enabled;
  logic active;

  assign enabled   = (ctl_q.level != '0);
  assign active    = pend_q && enabled;
  assign irq_pit   = active && (ctl_q.level >= ext_level);
  assign irq_level = irq_pit ? ctl_q.level : ext_level;
  assign vec_valid = ack_valid && active && (ack_level == ctl_q.level);
  assign vec_data  = vec_valid ? ctl_q.vector : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (expire && enabled)   pend_q <= 1'b1;
    else if (!enabled || vec_valid) pend_q <= 1'b0;
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int PRESC_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [2:0]  ext_level,
  input  logic        ack_valid,
  input  logic [2:0]  ack_level,
  output logic [2:0]  irq_level,
  output logic        irq_pit,
  output logic        vec_valid,
  output logic [7:0]  vec_data
);
  ctl_t             ctl_q;
  tmr_t             tmr_q;
  tmr_t             tmr_load_val;
  logic             tmr_load;
  logic             expire;
  logic [LVL_W-1:0] ctl_level;
  logic [VEC_W-1:0] ctl_vector;
  logic [MOD_W-1:0] tmr_mod;

  assign ctl_level  = ctl_q.level;
  assign ctl_vector = ctl_q.vector;
  assign tmr_mod    = tmr_q.modulus;

  pit_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_q(ctl_q),
    .tmr_q(tmr_q), .tmr_load(tmr_load), .tmr_load_val(tmr_load_val)
  );

  pit_counter #(.PRESC_DIV(PRESC_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tmr_q(tmr_q), .tmr_load(tmr_load),
    .tmr_load_val(tmr_load_val), .expire(expire)
  );

  pit_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ctl_q(ctl_q),
    .ext_level(ext_level), .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level), .irq_pit(irq_pit), .vec_valid(vec_valid),
    .vec_data(vec_data)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [15:0] reg_rdata,
  input logic [2:0]  ext_level,
  input logic        ack_valid,
  input logic [2:0]  ack_level,
  input logic [2:0]  irq_level,
  input logic        irq_pit,
  input logic        vec_valid,
  input logic [7:0]  vec_data,
  input logic        expire,
  input logic [2:0]  ctl_level,
  input logic [7:0]  ctl_vector,
  input logic [7:0]  tmr_mod
);
  p_ctl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> reg_rdata[15:11] == 5'd0);

  p_tmr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> reg_rdata[15:9] == 7'd0);

  p_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_mod == 8'd0) |-> !expire);

  p_lvl0_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_level == 3'd0) |-> !irq_pit);

  p_expire_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl_level != 3'd0 && !reg_wr) |=> (irq_level >= $past(ctl_level)));

  p_tie_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pit |-> (irq_level == ctl_level) && (ctl_level >= ext_level));

  p_vec_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ack_valid && (ack_level == ctl_level) && (vec_data == ctl_vector));

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !expire) |=> !irq_pit);
endmodule

bind pit_timer pit_timer_chk u_chk (.*);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  ext_level = '0;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_level = '0;
  logic [2:0]  irq_level;
  logic        irq_pit;
  logic        vec_valid;
  logic [7:0]  vec_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer #(.PRESC_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_level(ext_level),
    .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level),
    .irq_pit(irq_pit), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input bit a, input logic [15:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic quiesce();
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h000F);
    ext_level = '0;
  endtask

  task automatic t_reset();
    rd(1'b0, 16'h000F, "R2");
    rd(1'b1, 16'h0000, "R2");
    chk(irq_level == 3'd0 && !irq_pit, "R2", {irq_pit, irq_level}, 0);
  endtask

  task automatic t_regs();
    wr(1'b0, 16'hFFFF);
    rd(1'b0, 16'h07FF, "R1");
    wr(1'b0, 16'h05C3);
    rd(1'b0, 16'h05C3, "R1");
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, 16'h01FF, "R3");
    quiesce();
  endtask

  task automatic t_period();
    wr(1'b0, 16'h03A5);
    wr(1'b1, 16'h0005);
    step(4);
    chk(!irq_pit, "R4", irq_pit, 0);
    step(1);
    chk(irq_pit && irq_level == 3'd3, "R4", {irq_pit, irq_level}, 4'hB);
    ack_valid = 1'b1; ack_level = 3'd3;
    #1;
    chk(vec_valid && vec_data == 8'hA5, "R10", {vec_valid, vec_data}, 9'h1A5);
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
    chk(!irq_pit, "R10", irq_pit, 0);
    step(3);
    chk(!irq_pit, "R4", irq_pit, 0);
    step(1);
    chk(irq_pit, "R4", irq_pit, 1);
    quiesce();
  endtask

  task automatic t_prescale();
    wr(1'b0, 16'h0300);
    wr(1'b1, 16'h0103);
    step(3 * DIV - 1);
    chk(!irq_pit, "R5", irq_pit, 0);
    step(1);
    chk(irq_pit, "R5", irq_pit, 1);
    quiesce();
  endtask

  task automatic t_stop();
    wr(1'b0, 16'h0300);
    wr(1'b1, 16'h0000);
    step(40);
    chk(!irq_pit && irq_level == 3'd0, "R6", {irq_pit, irq_level}, 0);
    quiesce();
  endtask

  task automatic t_disabled();
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0005);
    step(6);
    chk(!irq_pit, "R7", irq_pit, 0);
    wr(1'b0, 16'h0300);
    chk(!irq_pit, "R7", irq_pit, 0);
    step(2);
    chk(!irq_pit, "R7", irq_pit, 0);
    step(1);
    chk(irq_pit && irq_level == 3'd3, "R7", {irq_pit, irq_level}, 4'hB);
    quiesce();
  endtask

  task automatic t_prio();
    wr(1'b0, 16'h0342);
    wr(1'b1, 16'h0001);
    step(1);
    wr(1'b1, 16'h0000);
    ext_level = 3'd2;
    #1;
    chk(irq_pit && irq_level == 3'd3, "R8", {irq_pit, irq_level}, 4'hB);
    ext_level = 3'd3;
    #1;
    chk(irq_pit && irq_level == 3'd3, "R9", {irq_pit, irq_level}, 4'hB);
    ext_level = 3'd5;
    #1;
    chk(!irq_pit && irq_level == 3'd5, "R9", {irq_pit, irq_level}, 4'h5);
    ext_level = 3'd0;
    ack_valid = 1'b1; ack_level = 3'd2;
    #1;
    chk(!vec_valid, "R10", vec_valid, 0);
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
    chk(irq_pit, "R10", irq_pit, 1);
    ack_valid = 1'b1; ack_level = 3'd3;
    #1;
    chk(vec_valid && vec_data == 8'h42, "R10", {vec_valid, vec_data}, 9'h142);
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
    chk(!irq_pit && irq_level == 3'd0, "R10", {irq_pit, irq_level}, 0);
    quiesce();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_regs();
    t_period();
    t_prescale();
    t_stop();
    t_disabled();
    t_prio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule